// File: doc/BRIEF.md
# Trace Input Stimulus Selector

This block sits in front of a trace unit and produces three of its inputs: a 4-bit external-input vector, a 20-bit event bus and a single trace-ready line. For each of them, a 2-bit field in a select register chooses where the value comes from. The choices are a constant, a value held in a software register, bits of a free-running pseudo-random generator, or the live processor signal. Live processor values give normal operation. The other sources inject known or random stimulus into the trace unit for testing.

Four read/write control registers are reached through a simple word port: one write strobe, a 2-bit register index, write data, and read data that follows the index combinationally. One register also holds capability values, which are driven out as fixed-width fields. A force bit in that register is ORed into a wait-for-interrupt-pending line that passes through the block. The pseudo-random source is a 20-bit maximal-length LFSR with feedback taps at stages 20 and 17. It steps on every clock once reset is released.

Top module: `trace_stim_sel`

## Requirements
- R1: While rst_n is low, and after it is released, the registers hold their reset values: index 0 = 0x0, index 1 = 0x110, index 2 = 0x0, index 3 = 0x0. With these values trc_extin = 0, trc_evt = 0 and trc_ready = 1. Pulling rst_n low clears the registers at once, with no clock edge needed.
- R2: A write with reg_wr high updates the register at reg_addr at that clock edge. Register widths are: index 0 is 4 bits, index 1 is 11 bits, index 2 is 20 bits, index 3 is 6 bits. Write-data bits above a register's width are ignored, and reg_rdata returns zero in those positions.
- R3: Select bits [1:0] (register index 3) drive trc_extin. 00 gives 0, 01 gives register index 0 bits [3:0], 10 gives {dbg_ack, random[2:0]}, and 11 gives {3'b000, cpu_extin}.
- R4: Select bits [3:2] drive trc_evt. 00 gives 0, 01 gives register index 2 bits [19:0], 10 gives random[19:0], and 11 gives cpu_evt.
- R5: Select bits [5:4] drive trc_ready. 00 gives 1, 01 gives random[0], 10 gives 0, and 11 gives insn_exec.
- R6: Register index 1 drives the capability outputs: cap_max_extin from bits [2:0], cap_max_extout from bits [5:3] and cap_max_port from bits [9:6]. wfi_pend_out = wfi_pend_in OR bit [10].
- R7: The random value is never zero. From one clock to the next it steps as next = {cur[18:0], cur[19] ^ cur[16]}.
- R8: The outputs follow a new select or register value in the cycle right after the write edge. No extra pipeline stage sits between the registers and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the indexed register, reserved bits zero |
| cpu_evt | input | 20 | Processor event bus |
| cpu_extin | input | 1 | Processor external-input bit |
| dbg_ack | input | 1 | Debug acknowledge |
| insn_exec | input | 1 | Instruction-executed strobe |
| wfi_pend_in | input | 1 | Incoming wait-for-interrupt-pending |
| trc_extin | output | 4 | Selected external inputs to the trace unit |
| trc_evt | output | 20 | Selected event bus to the trace unit |
| trc_ready | output | 1 | Selected trace-ready |
| cap_max_extin | output | 3 | Capability: maximum external inputs |
| cap_max_extout | output | 3 | Capability: maximum external outputs |
| cap_max_port | output | 4 | Capability: maximum port size |
| wfi_pend_out | output | 1 | wfi_pend_in ORed with the force bit |

## Verification
The bench walks each 2-bit select through all four codes. A swapped or misdecoded code would route the wrong source, for example live processor values in place of a constant, or an inverted trace-ready. It writes all-ones to every register and reads the values back. A design that stored reserved bits, or got a reset value wrong (above all the nonzero capability defaults), would fail on readback. With the random sources selected, it checks that each sampled random word follows the recurrence from the one before it. It also checks that the external-input and trace-ready outputs pick the right random bits together with the debug acknowledge. A wrong tap, a generator that stalls, or a bit slice taken from the wrong end would each break one of these checks. A reset pulled low mid-run must clear the registers before any clock edge.

// File: rtl/trace_stim_pkg.sv
package trace_stim_pkg;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 2;
  localparam int EXT_W        = 4;
  localparam int EVT_W        = 20;
  localparam int SEL_W        = 6;
  localparam int CAP_IN_W     = 3;
  localparam int CAP_OUT_W    = 3;
  localparam int CAP_PORT_W   = 4;
  localparam int CAPS_W       = CAP_IN_W + CAP_OUT_W + CAP_PORT_W + 1;

  localparam int CAP_IN_LSB   = 0;
  localparam int CAP_OUT_LSB  = CAP_IN_LSB + CAP_IN_W;
  localparam int CAP_PORT_LSB = CAP_OUT_LSB + CAP_OUT_W;
  localparam int WFI_FORCE_BIT = CAP_PORT_LSB + CAP_PORT_W;

  localparam logic [CAP_IN_W-1:0]   CAP_IN_RST   = 3'b000;
  localparam logic [CAP_OUT_W-1:0]  CAP_OUT_RST  = 3'b010;
  localparam logic [CAP_PORT_W-1:0] CAP_PORT_RST = 4'b0100;
  localparam logic [CAPS_W-1:0]     CAPS_RST     = {1'b0, CAP_PORT_RST, CAP_OUT_RST, CAP_IN_RST};

  typedef enum logic [ADDR_W-1:0] {
    IDX_EXTIN  = 2'd0,
    IDX_CAPS   = 2'd1,
    IDX_EVENT  = 2'd2,
    IDX_SELECT = 2'd3
  } reg_idx_e;

  localparam int SEL_EXT_LSB = 0;
  localparam int SEL_EVT_LSB = 2;
  localparam int SEL_RDY_LSB = 4;
endpackage

// File: rtl/tss_lfsr.sv
module tss_lfsr #(
  parameter int WIDTH = 20,
  parameter int TAP_A = 20,
  parameter int TAP_B = 17,
  parameter logic [WIDTH-1:0] SEED = 20'hACE1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             step_en,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] q, d;
  logic             fb;

  always_comb begin
    fb = q[TAP_A-1] ^ q[TAP_B-1];
    d  = q;
    if (step_en) d = {q[WIDTH-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= d;
  end

  assign value = q;
endmodule

// File: rtl/tss_regs.sv
module tss_regs
  import trace_stim_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [EXT_W-1:0]   ext_q,
  output logic [CAPS_W-1:0]  caps_q,
  output logic [EVT_W-1:0]   evt_q,
  output logic [SEL_W-1:0]   sel_q
);
  logic [EXT_W-1:0]  ext_d;
  logic [CAPS_W-1:0] caps_d;
  logic [EVT_W-1:0]  evt_d;
  logic [SEL_W-1:0]  sel_d;
  logic ext_en, caps_en, evt_en, sel_en;

  always_comb begin
    ext_en  = wr && (addr == IDX_EXTIN);
    caps_en = wr && (addr == IDX_CAPS);
    evt_en  = wr && (addr == IDX_EVENT);
    sel_en  = wr && (addr == IDX_SELECT);
    ext_d   = ext_en  ? wdata[EXT_W-1:0]  : ext_q;
    caps_d  = caps_en ? wdata[CAPS_W-1:0] : caps_q;
    evt_d   = evt_en  ? wdata[EVT_W-1:0]  : evt_q;
    sel_d   = sel_en  ? wdata[SEL_W-1:0]  : sel_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q  <= '0;
      caps_q <= CAPS_RST;
      evt_q  <= '0;
      sel_q  <= '0;
    end else begin
      ext_q  <= ext_d;
      caps_q <= caps_d;
      evt_q  <= evt_d;
      sel_q  <= sel_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      IDX_EXTIN:  rdata[EXT_W-1:0]  = ext_q;
      IDX_CAPS:   rdata[CAPS_W-1:0] = caps_q;
      IDX_EVENT:  rdata[EVT_W-1:0]  = evt_q;
      default:    rdata[SEL_W-1:0]  = sel_q;
    endcase
  end
endmodule

// File: rtl/tss_src_mux.sv
module tss_src_mux
  import trace_stim_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic [EXT_W-1:0] ext_reg,
  input  logic [EVT_W-1:0] evt_reg,
  input  logic [EVT_W-1:0] rnd,
  input  logic [EVT_W-1:0] cpu_evt,
  input  logic             cpu_extin,
  input  logic             dbg_ack,
  input  logic             insn_exec,
  output logic [EXT_W-1:0] extin_o,
  output logic [EVT_W-1:0] evt_o,
  output logic             ready_o
);
  logic [1:0] s_ext, s_evt, s_rdy;

  always_comb begin
    s_ext = sel[SEL_EXT_LSB +: 2];
    s_evt = sel[SEL_EVT_LSB +: 2];
    s_rdy = sel[SEL_RDY_LSB +: 2];

    case (s_ext)
      2'b00:   extin_o = '0;
      2'b01:   extin_o = ext_reg;
      2'b10:   extin_o = {dbg_ack, rnd[EXT_W-2:0]};
      default: extin_o = {{(EXT_W-1){1'b0}}, cpu_extin};
    endcase

    case (s_evt)
      2'b00:   evt_o = '0;
      2'b01:   evt_o = evt_reg;
      2'b10:   evt_o = rnd;
      default: evt_o = cpu_evt;
    endcase

    case (s_rdy)
      2'b00:   ready_o = 1'b1;
      2'b01:   ready_o = rnd[0];
      2'b10:   ready_o = 1'b0;
      default: ready_o = insn_exec;
    endcase
  end
endmodule

// File: rtl/trace_stim_sel.sv
module trace_stim_sel
  import trace_stim_pkg::*;
#(
  parameter logic [EVT_W-1:0] LFSR_SEED = 20'hACE1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [EVT_W-1:0]      cpu_evt,
  input  logic                  cpu_extin,
  input  logic                  dbg_ack,
  input  logic                  insn_exec,
  input  logic                  wfi_pend_in,
  output logic [EXT_W-1:0]      trc_extin,
  output logic [EVT_W-1:0]      trc_evt,
  output logic                  trc_ready,
  output logic [CAP_IN_W-1:0]   cap_max_extin,
  output logic [CAP_OUT_W-1:0]  cap_max_extout,
  output logic [CAP_PORT_W-1:0] cap_max_port,
  output logic                  wfi_pend_out
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  logic [EXT_W-1:0]  ext_q;
  logic [CAPS_W-1:0] caps_q;
  logic [EVT_W-1:0]  evt_q;
  logic [SEL_W-1:0]  sel_q;
  logic [EVT_W-1:0]  rnd_q;

  tss_regs u_regs (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .ext_q  (ext_q),
    .caps_q (caps_q),
    .evt_q  (evt_q),
    .sel_q  (sel_q)
  );

  tss_lfsr #(
    .WIDTH (EVT_W),
    .TAP_A (20),
    .TAP_B (17),
    .SEED  (LFSR_SEED)
  ) u_lfsr (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .step_en (1'b1),
    .value   (rnd_q)
  );

  tss_src_mux u_mux (
    .sel       (sel_q),
    .ext_reg   (ext_q),
    .evt_reg   (evt_q),
    .rnd       (rnd_q),
    .cpu_evt   (cpu_evt),
    .cpu_extin (cpu_extin),
    .dbg_ack   (dbg_ack),
    .insn_exec (insn_exec),
    .extin_o   (trc_extin),
    .evt_o     (trc_evt),
    .ready_o   (trc_ready)
  );

  assign cap_max_extin  = caps_q[CAP_IN_LSB   +: CAP_IN_W];
  assign cap_max_extout = caps_q[CAP_OUT_LSB  +: CAP_OUT_W];
  assign cap_max_port   = caps_q[CAP_PORT_LSB +: CAP_PORT_W];
  assign wfi_pend_out   = wfi_pend_in | caps_q[WFI_FORCE_BIT];
endmodule

// File: rtl/tss_checker.sv
module tss_checker
  import trace_stim_pkg::*;
(
  input logic             clk,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel,
  input logic [EVT_W-1:0] rnd,
  input logic [EVT_W-1:0] cpu_evt,
  input logic             cpu_extin,
  input logic             insn_exec,
  input logic             wfi_pend_in,
  input logic             wfi_pend_out,
  input logic [EXT_W-1:0] trc_extin,
  input logic [EVT_W-1:0] trc_evt,
  input logic             trc_ready
);
  a_r3_extin_cpu: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel[1:0] == 2'b11) |-> (trc_extin == {3'b000, cpu_extin}));

  a_r3_extin_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel[1:0] == 2'b00) |-> (trc_extin == '0));

  a_r4_evt_cpu: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel[3:2] == 2'b11) |-> (trc_evt == cpu_evt));

  a_r5_ready_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel[5:4] == 2'b10) |-> !trc_ready);

  a_r5_ready_insn: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel[5:4] == 2'b11) |-> (trc_ready == insn_exec));

  a_r6_wfi_pass: assert property (@(posedge clk) disable iff (!rst_ni)
    wfi_pend_in |-> wfi_pend_out);

  a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_ni)
    rnd != '0);

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(rst_ni) |-> (rnd == {$past(rnd[EVT_W-2:0]), $past(rnd[19] ^ rnd[16])}));
endmodule

bind trace_stim_sel tss_checker u_chk (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .sel          (sel_q),
  .rnd          (rnd_q),
  .cpu_evt      (cpu_evt),
  .cpu_extin    (cpu_extin),
  .insn_exec    (insn_exec),
  .wfi_pend_in  (wfi_pend_in),
  .wfi_pend_out (wfi_pend_out),
  .trc_extin    (trc_extin),
  .trc_evt      (trc_evt),
  .trc_ready    (trc_ready)
);

// File: tb/sim_trace_stim_sel.sv
module sim_trace_stim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [19:0] cpu_evt;
  logic        cpu_extin, dbg_ack, insn_exec, wfi_pend_in;
  logic [3:0]  trc_extin;
  logic [19:0] trc_evt;
  logic        trc_ready;
  logic [2:0]  cap_max_extin, cap_max_extout;
  logic [3:0]  cap_max_port;
  logic        wfi_pend_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_stim_sel u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_evt(cpu_evt),
    .cpu_extin(cpu_extin), .dbg_ack(dbg_ack), .insn_exec(insn_exec),
    .wfi_pend_in(wfi_pend_in), .trc_extin(trc_extin), .trc_evt(trc_evt),
    .trc_ready(trc_ready), .cap_max_extin(cap_max_extin),
    .cap_max_extout(cap_max_extout), .cap_max_port(cap_max_port),
    .wfi_pend_out(wfi_pend_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] lfsr_next(input logic [19:0] x);
    return {x[18:0], x[19] ^ x[16]};
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rd_reg(2'd1, d); check("R1 caps during reset", d, 32'h110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(2'd0, d); check("R1 extin reg", d, 32'h0);
    rd_reg(2'd1, d); check("R1 caps reg", d, 32'h110);
    rd_reg(2'd2, d); check("R1 event reg", d, 32'h0);
    rd_reg(2'd3, d); check("R1 select reg", d, 32'h0);
    check("R1 trc_extin", {28'h0, trc_extin}, 32'h0);
    check("R1 trc_evt", {12'h0, trc_evt}, 32'h0);
    check("R1 trc_ready", {31'h0, trc_ready}, 32'h1);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int i = 0; i < 4; i++) wr_reg(i[1:0], 32'hFFFF_FFFF);
    rd_reg(2'd0, d); check("R2 extin width", d, 32'hF);
    rd_reg(2'd1, d); check("R2 caps width", d, 32'h7FF);
    rd_reg(2'd2, d); check("R2 event width", d, 32'hF_FFFF);
    rd_reg(2'd3, d); check("R2 select width", d, 32'h3F);
    wr_reg(2'd0, 32'hA5A5_A5A6);
    rd_reg(2'd0, d); check("R2 extin value", d, 32'h6);
    wr_reg(2'd2, 32'h1234_5678);
    rd_reg(2'd2, d); check("R2 event value", d, 32'h4_5678);
  endtask

  task automatic t_extin();
    wr_reg(2'd0, 32'h9);
    wr_reg(2'd3, 32'h00);
    check("R3 sel00 zero", {28'h0, trc_extin}, 32'h0);
    wr_reg(2'd3, 32'h01);
    check("R3 sel01 reg (R8 next cycle)", {28'h0, trc_extin}, 32'h9);
    cpu_extin = 1'b1;
    wr_reg(2'd3, 32'h03);
    check("R3 sel11 cpu high", {28'h0, trc_extin}, 32'h1);
    @(negedge clk); cpu_extin = 1'b0; #1;
    check("R3 sel11 cpu low", {28'h0, trc_extin}, 32'h0);
  endtask

  task automatic t_event();
    wr_reg(2'd2, 32'hB_EEF1);
    wr_reg(2'd3, 32'h04);
    check("R4 sel01 reg", {12'h0, trc_evt}, 32'hB_EEF1);
    cpu_evt = 20'h5_A5A5;
    wr_reg(2'd3, 32'h0C);
    check("R4 sel11 cpu", {12'h0, trc_evt}, 32'h5_A5A5);
    @(negedge clk); cpu_evt = 20'h0_3C3C; #1;
    check("R4 sel11 cpu follows", {12'h0, trc_evt}, 32'h0_3C3C);
    wr_reg(2'd3, 32'h00);
    check("R4 sel00 zero", {12'h0, trc_evt}, 32'h0);
  endtask

  task automatic t_ready();
    wr_reg(2'd3, 32'h20);
    check("R5 sel10 low", {31'h0, trc_ready}, 32'h0);
    wr_reg(2'd3, 32'h00);
    check("R5 sel00 high", {31'h0, trc_ready}, 32'h1);
    insn_exec = 1'b1;
    wr_reg(2'd3, 32'h30);
    check("R5 sel11 insn high", {31'h0, trc_ready}, 32'h1);
    @(negedge clk); insn_exec = 1'b0; #1;
    check("R5 sel11 insn low", {31'h0, trc_ready}, 32'h0);
  endtask

  task automatic t_random();
    logic [19:0] prev;
    wr_reg(2'd3, 32'h1A);
    #1 prev = trc_evt;
    check("R7 random nonzero", {31'h0, (prev != 20'h0)}, 32'h1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      dbg_ack = i[1];
      #1;
      check("R7 random step", {12'h0, trc_evt}, {12'h0, lfsr_next(prev)});
      check("R3 sel10 dbg+random", {28'h0, trc_extin}, {28'h0, dbg_ack, trc_evt[2:0]});
      check("R5 sel01 random bit0", {31'h0, trc_ready}, {31'h0, trc_evt[0]});
      prev = trc_evt;
    end
    dbg_ack = 1'b0;
  endtask

  task automatic t_caps();
    wr_reg(2'd1, 32'h110);
    check("R6 cap extin reset", {29'h0, cap_max_extin}, 32'h0);
    check("R6 cap extout reset", {29'h0, cap_max_extout}, 32'h2);
    check("R6 cap port reset", {28'h0, cap_max_port}, 32'h4);
    wfi_pend_in = 1'b0; #1;
    check("R6 wfi no force", {31'h0, wfi_pend_out}, 32'h0);
    wr_reg(2'd1, 32'h5EB);
    check("R6 cap extin", {29'h0, cap_max_extin}, 32'h3);
    check("R6 cap extout", {29'h0, cap_max_extout}, 32'h5);
    check("R6 cap port", {28'h0, cap_max_port}, 32'h7);
    check("R6 wfi forced", {31'h0, wfi_pend_out}, 32'h1);
    wr_reg(2'd1, 32'h0);
    wfi_pend_in = 1'b1; #1;
    check("R6 wfi pass", {31'h0, wfi_pend_out}, 32'h1);
    wfi_pend_in = 1'b0;
  endtask

  task automatic t_async_reset();
    logic [31:0] d;
    wr_reg(2'd3, 32'h3F);
    wr_reg(2'd0, 32'hC);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 reg_addr = 2'd3;
    #1 check("R1 async clear select", reg_rdata, 32'h0);
    check("R1 async ready high", {31'h0, trc_ready}, 32'h1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(2'd0, d); check("R1 extin after reset", d, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    cpu_evt = '0; cpu_extin = 1'b0; dbg_ack = 1'b0; insn_exec = 1'b0; wfi_pend_in = 1'b0;
    t_reset();
    t_regs();
    do_reset();
    t_extin();
    t_event();
    t_ready();
    t_random();
    t_caps();
    t_async_reset();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule